// File: doc/BRIEF.md
# DMA Channel Activation Controller

This block keeps the run/stop control state for a group of DMA channels. Each channel is enabled by software, optionally tied to one of several hardware request lines, and set to advance in steps of one element, one frame or one whole block. The block decides, cycle by cycle, which channels are active and may move data. It holds at most one queued request per channel and flags any further request that arrives as a dropped event. At the end of a block it applies the channel's block-end policy: stop, reload and run again, park until an end-programming command, or stop and start a linked channel.

The address datapath is outside this block. It reports progress through three per-channel pulses: element done, frame end and block end. A frame end is given together with its element done, and a block end together with its frame end. Requests arrive as a single event per cycle, written as `req_valid` plus a line number. The block never stalls them, so this input has no ready signal and no back-pressure. Control inputs and status outputs are plain levels or single-cycle pulses. Every status output is registered and shows the effect of an input on the clock edge at which that input is sampled.

Top module: `dma_req_sync`

## Requirements
- R1: After reset, every channel is disabled, inactive, idle and not waiting, with no pulse outputs, `run_count` equal to 0 and `busy` low.
- R2: An enable pulse to a disabled channel sets it enabled, clears its waiting state and gives one `ch_reload` pulse. The channel is active at once if its line selector is 0 (unsynchronized) or the selected request line is high.
- R3: A request event (`req_valid` with `req_id` equal to a channel's nonzero selector) activates an enabled, inactive channel. If the channel is already active with nothing queued, the event queues one request. Events with `req_id` 0 and events to disabled channels change nothing.
- R4: A request event to a channel that is active and already has a queued request raises `ch_drop` for one cycle and leaves the queued request in place.
- R5: A synchronized channel with neither frame-step nor block-step set stops after each element done. One with frame-step set stops only at a frame end. An unsynchronized channel never stops on element or frame events.
- R6: When a stop is due and a request is queued while the channel is not waiting, the queued request is consumed and the channel stays active.
- R7: When a stop is due and the channel's selected request line is still high, the channel stays active.
- R8: In extended mode a block end disables the channel. If linking is on, the channel numbered in its link field is enabled one cycle later, with its own reload pulse.
- R9: In legacy mode a block end disables the channel when auto-init is off. It gives a reload pulse and keeps running when auto-init is on with repeat or the end-program flag set. Otherwise it sets the waiting state and stops.
- R10: A disable pulse clears enable, active, queued request and waiting state in one cycle.
- R11: An end-programming command to a waiting channel clears the wait. It activates the channel if the channel is unsynchronized or has a request queued, and otherwise leaves it inactive.
- R12: The sync-status bit of a channel is set when a synchronized channel becomes active and clears whenever the channel stops.
- R13: `run_count` equals the number of active channels, and `busy` is high exactly when it is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_lines | input | NLINE | Request line levels, indexed by selector (line 0 unused) |
| req_valid | input | 1 | Request event this cycle |
| req_id | input | SW | Line number of the request event |
| cfg_sync_sel | input | NCH*SW | Per-channel line selector, 0 = unsynchronized |
| cfg_frame_sync | input | NCH | Per-channel frame-step mode |
| cfg_block_sync | input | NCH | Per-channel block-step mode |
| cfg_ext_mode | input | NCH | Per-channel extended (linking) block-end policy |
| cfg_auto_init | input | NCH | Per-channel legacy auto-init |
| cfg_repeat | input | NCH | Per-channel legacy repeat |
| cfg_endprog | input | NCH | Per-channel end-program flag |
| cfg_link_en | input | NCH | Per-channel link enable |
| cfg_link_next | input | NCH*CW | Per-channel linked channel number |
| ch_enable_set | input | NCH | Enable pulses |
| ch_enable_clr | input | NCH | Disable pulses |
| ch_endprog_cmd | input | NCH | End-programming command pulses |
| xfer_elem | input | NCH | Element-done pulses from the datapath |
| xfer_frame | input | NCH | Frame-end pulses |
| xfer_block | input | NCH | Block-end pulses |
| ch_enabled | output | NCH | Channel enabled |
| ch_active | output | NCH | Channel active |
| ch_pending | output | NCH | Queued request held |
| ch_waiting | output | NCH | Waiting for end-programming |
| ch_sync_stat | output | NCH | Synchronized-active status |
| ch_drop | output | NCH | Dropped-request pulse |
| ch_reload | output | NCH | Reload-parameters pulse |
| run_count | output | RW | Number of active channels |
| busy | output | 1 | Any channel active |

## Verification
Assertions check on every cycle that a disabled channel holds no activity, queue or wait, that sync status never appears on an inactive channel, and that a drop happens only with a request already queued. They also check that each rising enable comes with a reload pulse, that a link request leaves its source disabled, and that the run counter always matches the count of active channels. The bench scenarios cover the ordering behaviour: a queued request consumed instead of a stop, a high line holding a channel active, and the element and frame stop points. They also cover the three legacy block-end outcomes, the one-cycle delay of a linked enable, and end-programming both with and without reactivation.

// File: rtl/dma_sync_pkg.sv
package dma_sync_pkg;

  // Control state held for one channel
  typedef struct packed {
    logic en;    // enabled by software or link
    logic act;   // allowed to move data
    logic pend;  // one queued request
    logic wt;    // parked until end-programming command
    logic sst;   // synchronized-active status
  } chan_state_t;

  function automatic int unsigned ones(input logic [31:0] v, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < n; i++) c += int'(v[i]);
    return c;
  endfunction

endpackage

// File: rtl/dma_sync_chan.sv
module dma_sync_chan
  import dma_sync_pkg::*;
#(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sync_sel,
  input  logic          frame_sync,
  input  logic          block_sync,
  input  logic          ext_mode,
  input  logic          auto_init,
  input  logic          repeat_mode,
  input  logic          endprog_flag,
  input  logic          link_en,
  input  logic          line_hi,
  input  logic          req_hit,
  input  logic          en_cmd,
  input  logic          dis_cmd,
  input  logic          ep_cmd,
  input  logic          elem_done,
  input  logic          frame_end,
  input  logic          block_end,
  output chan_state_t   state_o,
  output logic          act_next_o,
  output logic          drop_o,
  output logic          reload_o,
  output logic          link_o
);

  chan_state_t cur, nxt;
  logic        drop_n, rld_n, drop_q, rld_q;
  logic        synced;

  assign synced = (sync_sel != '0);

  // Attempt to stop: a queued request or a still-high line keeps it running
  function automatic chan_state_t try_stop(input chan_state_t s, input logic syn,
                                           input logic hi);
    chan_state_t r;
    r = s;
    if (s.pend && !s.wt) r.pend = 1'b0;
    else if (!(syn && hi)) r.act = 1'b0;
    return r;
  endfunction

  always_comb begin
    nxt    = cur;
    rld_n  = 1'b0;
    drop_n = 1'b0;
    link_o = 1'b0;
    if (dis_cmd) begin
      nxt = '0;
    end else if (en_cmd && !cur.en) begin
      nxt.en = 1'b1;
      nxt.wt = 1'b0;
      rld_n  = 1'b1;
      if (!synced || line_hi) nxt.act = 1'b1;
    end else if (cur.en) begin
      if (ep_cmd && cur.wt) begin
        nxt.wt = 1'b0;
        if (!synced || cur.pend) begin
          nxt.pend = 1'b0;
          nxt.act  = 1'b1;
        end
      end
      if (cur.act) begin
        if (synced && ((elem_done && !frame_sync && !block_sync) ||
                       (frame_end && frame_sync)))
          nxt = try_stop(nxt, synced, line_hi);
        if (block_end) begin
          if (ext_mode) begin
            nxt    = '0;
            link_o = link_en;
          end else if (!auto_init) begin
            nxt = '0;
          end else if (repeat_mode || endprog_flag) begin
            rld_n = 1'b1;
          end else begin
            nxt.wt = 1'b1;
            nxt    = try_stop(nxt, synced, line_hi);
          end
        end
      end
      if (nxt.en && req_hit) begin
        if (!nxt.act)       nxt.act  = 1'b1;
        else if (!nxt.pend) nxt.pend = 1'b1;
        else                drop_n   = 1'b1;
      end
    end
    nxt.sst = nxt.act && (cur.act ? cur.sst : synced);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur    <= '0;
      drop_q <= 1'b0;
      rld_q  <= 1'b0;
    end else begin
      cur    <= nxt;
      drop_q <= drop_n;
      rld_q  <= rld_n;
    end
  end

  assign state_o    = cur;
  assign act_next_o = nxt.act;
  assign drop_o     = drop_q;
  assign reload_o   = rld_q;

  // R10: a disabled channel carries no activity, queue or wait
  a_r10_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cur.en |-> (!cur.act && !cur.pend && !cur.wt));

  // R12: sync status only on an active channel
  a_r12_sync_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    cur.sst |-> cur.act);

  // R4: a drop only happens with a request already queued on an active channel
  a_r4_drop_with_pending: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q |-> (cur.pend && cur.act));

  // R2: every rising enable is accompanied by a reload pulse
  a_r2_reload_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cur.en) |-> rld_q);

  // R8: a channel that requests a link is disabled afterwards
  a_r8_link_source_off: assert property (@(posedge clk) disable iff (!rst_n)
    link_o |=> !cur.en);

endmodule

// File: rtl/dma_sync_runcnt.sv
module dma_sync_runcnt
  import dma_sync_pkg::*;
#(
  parameter int NCH = 4,
  parameter int RW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] act_cur,
  input  logic [NCH-1:0] act_nxt,
  output logic [RW-1:0]  run_q
);

  logic [NCH-1:0] rise, fall;
  logic [RW-1:0]  n_rise, n_fall;

  assign rise   = act_nxt & ~act_cur;
  assign fall   = act_cur & ~act_nxt;
  assign n_rise = RW'(ones(32'(rise), NCH));
  assign n_fall = RW'(ones(32'(fall), NCH));

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_q + n_rise - n_fall;
  end

  // R13: the incremental counter tracks the active population
  a_r13_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    run_q == RW'(ones(32'(act_cur), NCH)));

endmodule

// File: rtl/dma_req_sync.sv
module dma_req_sync
  import dma_sync_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NLINE = 8,
  localparam int SW   = (NLINE > 1) ? $clog2(NLINE) : 1,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RW   = $clog2(NCH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINE-1:0]  req_lines,
  input  logic              req_valid,
  input  logic [SW-1:0]     req_id,
  input  logic [NCH*SW-1:0] cfg_sync_sel,
  input  logic [NCH-1:0]    cfg_frame_sync,
  input  logic [NCH-1:0]    cfg_block_sync,
  input  logic [NCH-1:0]    cfg_ext_mode,
  input  logic [NCH-1:0]    cfg_auto_init,
  input  logic [NCH-1:0]    cfg_repeat,
  input  logic [NCH-1:0]    cfg_endprog,
  input  logic [NCH-1:0]    cfg_link_en,
  input  logic [NCH*CW-1:0] cfg_link_next,
  input  logic [NCH-1:0]    ch_enable_set,
  input  logic [NCH-1:0]    ch_enable_clr,
  input  logic [NCH-1:0]    ch_endprog_cmd,
  input  logic [NCH-1:0]    xfer_elem,
  input  logic [NCH-1:0]    xfer_frame,
  input  logic [NCH-1:0]    xfer_block,
  output logic [NCH-1:0]    ch_enabled,
  output logic [NCH-1:0]    ch_active,
  output logic [NCH-1:0]    ch_pending,
  output logic [NCH-1:0]    ch_waiting,
  output logic [NCH-1:0]    ch_sync_stat,
  output logic [NCH-1:0]    ch_drop,
  output logic [NCH-1:0]    ch_reload,
  output logic [RW-1:0]     run_count,
  output logic              busy
);

  chan_state_t    st [NCH];
  logic [NCH-1:0] act_nxt, link_req, link_vec, link_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SW-1:0] sel;
    logic          hit, hi;
    assign sel = cfg_sync_sel[c*SW +: SW];
    assign hi  = (sel != '0) && req_lines[sel];
    assign hit = req_valid && (req_id != '0) && (req_id == sel);

    dma_sync_chan #(.SW(SW)) i_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_sel    (sel),
      .frame_sync  (cfg_frame_sync[c]),
      .block_sync  (cfg_block_sync[c]),
      .ext_mode    (cfg_ext_mode[c]),
      .auto_init   (cfg_auto_init[c]),
      .repeat_mode (cfg_repeat[c]),
      .endprog_flag(cfg_endprog[c]),
      .link_en     (cfg_link_en[c]),
      .line_hi     (hi),
      .req_hit     (hit),
      .en_cmd      (ch_enable_set[c] | link_q[c]),
      .dis_cmd     (ch_enable_clr[c]),
      .ep_cmd      (ch_endprog_cmd[c]),
      .elem_done   (xfer_elem[c]),
      .frame_end   (xfer_frame[c]),
      .block_end   (xfer_block[c]),
      .state_o     (st[c]),
      .act_next_o  (act_nxt[c]),
      .drop_o      (ch_drop[c]),
      .reload_o    (ch_reload[c]),
      .link_o      (link_req[c])
    );

    assign ch_enabled[c]   = st[c].en;
    assign ch_active[c]    = st[c].act;
    assign ch_pending[c]   = st[c].pend;
    assign ch_waiting[c]   = st[c].wt;
    assign ch_sync_stat[c] = st[c].sst;
  end

  // Route each link request to its target; enable lands one cycle later
  always_comb begin
    link_vec = '0;
    for (int c = 0; c < NCH; c++)
      if (link_req[c]) link_vec[cfg_link_next[c*CW +: CW]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) link_q <= '0;
    else        link_q <= link_vec;
  end

  dma_sync_runcnt #(.NCH(NCH), .RW(RW)) i_runcnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .act_cur(ch_active),
    .act_nxt(act_nxt),
    .run_q  (run_count)
  );

  assign busy = (run_count != '0);

  // R8: a pending link enable always yields an enabled target next cycle
  a_r8_link_target_on: assert property (@(posedge clk) disable iff (!rst_n)
    (link_q != '0) && ((link_q & ch_enable_clr) == '0) |=> ((link_q_d & ch_enabled) == link_q_d));

  logic [NCH-1:0] link_q_d;
  always_ff @(posedge clk) begin
    if (!rst_n) link_q_d <= '0;
    else        link_q_d <= link_q & ~ch_enable_clr;
  end

endmodule

// File: tb/test_dma_req_sync.sv
`timescale 1ns/1ps
module test_dma_req_sync;

  localparam int NCH = 4, NLINE = 8, SW = 3, CW = 2, RW = 3;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [NLINE-1:0]  req_lines = '0;
  logic              req_valid = 0;
  logic [SW-1:0]     req_id = '0;
  logic [NCH*SW-1:0] cfg_sync_sel;
  logic [NCH-1:0]    cfg_frame_sync, cfg_block_sync, cfg_ext_mode, cfg_auto_init;
  logic [NCH-1:0]    cfg_repeat, cfg_endprog, cfg_link_en;
  logic [NCH*CW-1:0] cfg_link_next;
  logic [NCH-1:0]    en_set = '0, en_clr = '0, ep_cmd = '0, x_el = '0, x_fr = '0, x_bl = '0;
  logic [NCH-1:0]    o_en, o_act, o_pend, o_wt, o_sst, o_drop, o_rld;
  logic [RW-1:0]     o_run;
  logic              o_busy;

  dma_req_sync #(.NCH(NCH), .NLINE(NLINE)) i_dma_req_sync (
    .clk(clk), .rst_n(rst_n), .req_lines(req_lines), .req_valid(req_valid), .req_id(req_id),
    .cfg_sync_sel(cfg_sync_sel), .cfg_frame_sync(cfg_frame_sync), .cfg_block_sync(cfg_block_sync),
    .cfg_ext_mode(cfg_ext_mode), .cfg_auto_init(cfg_auto_init), .cfg_repeat(cfg_repeat),
    .cfg_endprog(cfg_endprog), .cfg_link_en(cfg_link_en), .cfg_link_next(cfg_link_next),
    .ch_enable_set(en_set), .ch_enable_clr(en_clr), .ch_endprog_cmd(ep_cmd),
    .xfer_elem(x_el), .xfer_frame(x_fr), .xfer_block(x_bl),
    .ch_enabled(o_en), .ch_active(o_act), .ch_pending(o_pend), .ch_waiting(o_wt),
    .ch_sync_stat(o_sst), .ch_drop(o_drop), .ch_reload(o_rld), .run_count(o_run), .busy(o_busy)
  );

  typedef struct {
    int         due;
    string      tag;
    logic [3:0] en, act, pend, wt, sst, drop, rld;
    int         run;
  } exp_t;

  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare outputs with the expectation due this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (o_en !== e.en || o_act !== e.act || o_pend !== e.pend || o_wt !== e.wt ||
          o_sst !== e.sst || o_drop !== e.drop || o_rld !== e.rld ||
          int'(o_run) != e.run || o_busy !== (e.run != 0)) begin
        errors++;
        $display("FAIL %s: got en=%b act=%b pend=%b wt=%b sst=%b drop=%b rld=%b run=%0d busy=%b exp en=%b act=%b pend=%b wt=%b sst=%b drop=%b rld=%b run=%0d",
                 e.tag, o_en, o_act, o_pend, o_wt, o_sst, o_drop, o_rld, o_run, o_busy,
                 e.en, e.act, e.pend, e.wt, e.sst, e.drop, e.rld, e.run);
      end
    end
  end

  // Driver: inputs already set at a negedge; push expectation for after next edge
  task automatic tick(input string tag, input logic [3:0] en, act, pend, wt, sst, drop, rld,
                      input int run);
    exp_t e;
    e.due = cyc + 1; e.tag = tag; e.en = en; e.act = act; e.pend = pend; e.wt = wt;
    e.sst = sst; e.drop = drop; e.rld = rld; e.run = run;
    q.push_back(e);
    @(posedge clk);
    #1;
    req_valid = 0; en_set = '0; en_clr = '0; ep_cmd = '0; x_el = '0; x_fr = '0; x_bl = '0;
    @(negedge clk);
  endtask

  task automatic req(input int id);
    req_valid = 1; req_id = SW'(id);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // ch0: line 2 element-step legacy no auto; ch1: unsync extended link->2;
    // ch2: line 3 frame-step legacy auto-wait; ch3: unsync legacy auto
    cfg_sync_sel   = {3'd0, 3'd3, 3'd0, 3'd2};
    cfg_frame_sync = 4'b0100;
    cfg_block_sync = 4'b0000;
    cfg_ext_mode   = 4'b0010;
    cfg_auto_init  = 4'b1100;
    cfg_repeat     = 4'b0000;
    cfg_endprog    = 4'b0000;
    cfg_link_en    = 4'b0010;
    cfg_link_next  = {2'd0, 2'd0, 2'd2, 2'd0};
    repeat (3) @(negedge clk);
    rst_n = 1;

    tick("R1 reset", 0,0,0,0,0,0,0, 0);
    en_set = 4'b0001;           tick("R2 enable synced line low", 1,0,0,0,0,0,1, 0);
    req(2);                     tick("R3 activate R12 status", 1,1,0,0,1,0,0, 1);
    req(2);                     tick("R3 queue", 1,1,1,0,1,0,0, 1);
    req(2);                     tick("R4 collision", 1,1,1,0,1,1,0, 1);
    x_el = 4'b0001;             tick("R6 queue consumed", 1,1,0,0,1,0,0, 1);
    x_el = 4'b0001;             tick("R5 element stop R12", 1,0,0,0,0,0,0, 0);
    req_lines[2] = 1; req(2);   tick("R3 reactivate", 1,1,0,0,1,0,0, 1);
    x_el = 4'b0001;             tick("R7 line holds", 1,1,0,0,1,0,0, 1);
    req_lines[2] = 0; x_el = 4'b0001; tick("R5 stop line low", 1,0,0,0,0,0,0, 0);
    req(2);                     tick("R3 activate", 1,1,0,0,1,0,0, 1);
    req(2);                     tick("R3 queue", 1,1,1,0,1,0,0, 1);
    en_clr = 4'b0001;           tick("R10 disable drops queue", 0,0,0,0,0,0,0, 0);
    req_lines[2] = 1; en_set = 4'b0001; tick("R2 enable line high", 1,1,0,0,1,0,1, 1);
    req_lines[2] = 0; en_clr = 4'b0001; tick("R10 disable", 0,0,0,0,0,0,0, 0);
    req(2);                     tick("R3 disabled ignores", 0,0,0,0,0,0,0, 0);
    req(0);                     tick("R3 id zero ignored", 0,0,0,0,0,0,0, 0);
    en_set = 4'b0010;           tick("R2 unsync immediate", 2,2,0,0,0,0,2, 1);
    x_el = 4'b0010; x_fr = 4'b0010; tick("R5 unsync keeps running", 2,2,0,0,0,0,0, 1);
    x_el = 4'b0010; x_fr = 4'b0010; x_bl = 4'b0010; tick("R8 extended block end", 0,0,0,0,0,0,0, 0);
    tick("R8 linked enable", 4,0,0,0,0,0,4, 0);
    req(3);                     tick("R3 frame ch activate", 4,4,0,0,4,0,0, 1);
    x_el = 4'b0100;             tick("R5 frame-step ignores element", 4,4,0,0,4,0,0, 1);
    x_el = 4'b0100; x_fr = 4'b0100; tick("R5 frame stop", 4,0,0,0,0,0,0, 0);
    req(3);                     tick("R3 activate", 4,4,0,0,4,0,0, 1);
    x_el = 4'b0100; x_fr = 4'b0100; x_bl = 4'b0100; tick("R9 auto wait", 4,0,0,4,0,0,0, 0);
    ep_cmd = 4'b0100;           tick("R11 synced stays idle", 4,0,0,0,0,0,0, 0);
    en_set = 4'b1000;           tick("R2 unsync enable", 4'hC,8,0,0,0,0,8, 1);
    x_bl = 4'b1000;             tick("R9 unsync wait", 4'hC,0,0,8,0,0,0, 0);
    ep_cmd = 4'b1000;           tick("R11 endprog activates", 4'hC,8,0,0,0,0,0, 1);
    cfg_repeat = 4'b1000; x_bl = 4'b1000; tick("R9 repeat reload", 4'hC,8,0,0,0,0,8, 1);
    req(3);                     tick("R13 two active", 4'hC,4'hC,0,0,4,0,0, 2);
    en_clr = 4'b1100;           tick("R13 R10 both off", 0,0,0,0,0,0,0, 0);
    req_lines[2] = 1; en_set = 4'b0001; tick("R2 enable line high", 1,1,0,0,1,0,1, 1);
    req_lines[2] = 0; x_bl = 4'b0001; tick("R9 no auto disables", 0,0,0,0,0,0,0, 0);

    @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d unchecked expected 0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule